// File: doc/BRIEF.md
# Display Standby and Mode Controller

This block keeps the mode bits of a segment-display driver and turns them into the control levels used by the rest of the driver. A host-side serial decoder hands it complete register writes as a parallel byte, a strobe and a one-bit register select. Register 0 carries the two-bit duty field. Register 1 carries the standby bit and the display-enable bit.

From those bits the block derives several outputs:
- a duty divisor for the waveform generator;
- blanking levels for the common and segment drivers;
- an enable for the internal oscillator;
- the values driven onto two general-purpose output ports;
- the rotary-encoder inputs, passed through or masked.

It also turns key activity, plus any other request source, into the key-request flag seen by the host.

In standby, port A is pulled low and port B is frozen at the value it carried when standby was entered. The encoder inputs are masked, and only key activity may raise the key request. The oscillator then runs only while that request is up, so a key press wakes it and it stops one clock after the last key is released.

Top module: `dsc_top`

## Requirements
- R1: After a synchronous active-low reset, the duty code is 00, standby is 0 and display-enable is 0. As a result both blank outputs are 1, `osc_en` is 1 and `key_req` is 0.
- R2: Writing register 0 (`wr_sel`=0) loads `wr_data[1:0]` as the duty code. `duty_div` is 8 for code 00, 9 for code 01, and 10 for codes 10 and 11. Bits 7:2 of that write have no effect.
- R3: Writing register 1 (`wr_sel`=1) loads `wr_data[1]` into standby and `wr_data[0]` into display-enable. Bits 7:2 of that write have no effect, and a write to one register leaves the other unchanged.
- R4: `com_blank` and `seg_blank` are 1 whenever display-enable is 0 or standby is 1. Otherwise they are 0.
- R5: In standby `port_a_out` is all zeros. Outside standby it equals `port_a_in`.
- R6: `port_b_out` equals `port_b_in` outside standby. On the clock edge where standby goes from 0 to 1, `port_b_in` is captured, and `port_b_out` holds that value for the whole standby period.
- R7: In standby `enc_a_out` and `enc_b_out` are 0. Outside standby they follow `enc_a_in` and `enc_b_in`.
- R8: `key_req` is a register loaded each cycle from the request sources. It rises one clock after `key_act` rises and falls one clock after `key_act` falls, in either mode.
- R9: `aux_req` raises `key_req` one clock later outside standby, and is ignored in standby.
- R10: `osc_en` is 1 when standby is 0 or when `key_req` is 1, and is 0 otherwise.
- R11: A cycle with `wr_en`=0 changes no register, whatever `wr_sel` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = duty, 1 = standby/display |
| wr_data | input | 8 | Write data byte |
| key_act | input | 1 | Key-scan activity (any key down) |
| aux_req | input | 1 | Other request source for the key-request flag |
| port_a_in | input | PA_W | Requested value of output port A |
| port_b_in | input | PB_W | Requested value of output port B |
| enc_a_in | input | 1 | Rotary encoder phase A |
| enc_b_in | input | 1 | Rotary encoder phase B |
| duty_div | output | 4 | Display duty divisor (8, 9 or 10) |
| standby | output | 1 | Standby bit |
| disp_on | output | 1 | Display-enable bit |
| com_blank | output | 1 | Force common outputs to low supply |
| seg_blank | output | 1 | Force segment outputs to low supply |
| osc_en | output | 1 | Oscillator enable |
| port_a_out | output | PA_W | Port A drive value |
| port_b_out | output | PB_W | Port B drive value |
| enc_a_out | output | 1 | Encoder phase A after masking |
| enc_b_out | output | 1 | Encoder phase B after masking |
| key_req | output | 1 | Key-request flag to host |

## Verification
Two functions can act in the same cycle: the standby-entry write and the port B capture, and also a key release while the block sits in standby, where `key_req` falls and `osc_en` must fall with it.

The bench changes `port_b_in` right after the cycle of the entry write and judges the held value against the pre-change pattern. It then releases a key in standby and expects `key_req` and `osc_en` to drop together one clock later.

A further collision drives `aux_req` with `key_act` idle during standby. The expectation is that the request flag stays low, which shows the suppression applies in the very cycle the other source is active.

// File: rtl/dsc_pkg.sv
// Package: shared types and helpers for the display standby/mode controller.
// Assumes a two-bit duty code; divisor width fixed at 4 bits (max 10).
package dsc_pkg;

    localparam int DUTY_CODE_W = 2;
    localparam int DIV_W       = 4;

    typedef enum logic [DUTY_CODE_W-1:0] {
        DUTY_EIGHT = 2'b00,
        DUTY_NINE  = 2'b01,
        DUTY_TEN_A = 2'b10,
        DUTY_TEN_B = 2'b11
    } duty_code_e;

    // Map a duty code to its common-line divisor.
    function automatic logic [DIV_W-1:0] duty_to_div(input duty_code_e code);
        case (code)
            DUTY_EIGHT: duty_to_div = DIV_W'(8);
            DUTY_NINE:  duty_to_div = DIV_W'(9);
            default:    duty_to_div = DIV_W'(10);
        endcase
    endfunction

endpackage

// File: rtl/dsc_regs.sv
// Module: dsc_regs
// Holds the duty code, standby bit and display-enable bit. A write is taken
// when wr_en is high; wr_sel picks the register. Unused data bits are dropped.
// Also flags the write cycle that moves standby from 0 to 1.
// Assumes writes arrive already decoded and synchronous to clk.
module dsc_regs
    import dsc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output duty_code_e        duty_code,
    output logic              standby,
    output logic              disp_on,
    output logic              stb_enter
);

    localparam int STB_BIT  = 1;
    localparam int DISP_BIT = 0;

    logic wr_duty;
    logic wr_mode;

    // Decode which register a strobe targets.
    always_comb begin
        wr_duty = wr_en && !wr_sel;
        wr_mode = wr_en &&  wr_sel;
    end

    // Pulse on the write that turns standby on.
    always_comb stb_enter = wr_mode && wr_data[STB_BIT] && !standby;

    // Duty register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       duty_code <= DUTY_EIGHT;
        else if (wr_duty) duty_code <= duty_code_e'(wr_data[DUTY_CODE_W-1:0]);
    end

    // Standby and display-enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby <= 1'b0;
            disp_on <= 1'b0;
        end else if (wr_mode) begin
            standby <= wr_data[STB_BIT];
            disp_on <= wr_data[DISP_BIT];
        end
    end

endmodule

// File: rtl/dsc_wake.sv
// Module: dsc_wake
// Produces the registered key-request flag and the oscillator enable.
// In standby only key activity may raise the flag; the oscillator runs
// whenever standby is off or the flag is up.
// Assumes key_act and aux_req are already synchronous to clk.
module dsc_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic key_act,
    input  logic aux_req,
    output logic key_req,
    output logic osc_en
);

    logic req_next;

    // Collect request sources, dropping the others while in standby.
    always_comb req_next = key_act || (aux_req && !standby);

    // Register the flag so it trails its sources by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) key_req <= 1'b0;
        else        key_req <= req_next;
    end

    // Oscillator gate: free-running outside standby, key-driven inside.
    always_comb osc_en = !standby || key_req;

endmodule

// File: rtl/dsc_outs.sv
// Module: dsc_outs
// Applies the mode bits to the driver outputs: blanking, port A forcing,
// port B freezing and encoder masking. Port B's pre-standby value is
// captured on the edge where standby is entered.
// Assumes stb_enter is high only in the cycle of the entering write.
module dsc_outs #(
    parameter int PA_W = 4,
    parameter int PB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby,
    input  logic            disp_on,
    input  logic            stb_enter,
    input  logic [PA_W-1:0] port_a_in,
    input  logic [PB_W-1:0] port_b_in,
    input  logic            enc_a_in,
    input  logic            enc_b_in,
    output logic            com_blank,
    output logic            seg_blank,
    output logic [PA_W-1:0] port_a_out,
    output logic [PB_W-1:0] port_b_out,
    output logic            enc_a_out,
    output logic            enc_b_out
);

    logic [PB_W-1:0] pb_hold;
    logic            blank;

    // Blank both driver groups when display is off or in standby.
    always_comb blank = !disp_on || standby;
    always_comb com_blank = blank;
    always_comb seg_blank = blank;

    // Capture port B at standby entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         pb_hold <= '0;
        else if (stb_enter) pb_hold <= port_b_in;
    end

    // Per-bit port drive: A forced low, B frozen, while in standby.
    for (genvar i = 0; i < PA_W; i++) begin : g_pa
        always_comb port_a_out[i] = port_a_in[i] && !standby;
    end
    for (genvar j = 0; j < PB_W; j++) begin : g_pb
        always_comb port_b_out[j] = standby ? pb_hold[j] : port_b_in[j];
    end

    // Mask encoder phases in standby.
    always_comb begin
        enc_a_out = enc_a_in && !standby;
        enc_b_out = enc_b_in && !standby;
    end

endmodule

// File: rtl/dsc_top.sv
// Module: dsc_top
// Display standby and mode controller. Ties the register bank, the wake
// logic and the output conditioning together and exposes the duty divisor.
// Assumes a single clock domain and synchronous active-low reset.
module dsc_top
    import dsc_pkg::*;
#(
    parameter int PA_W   = 4,
    parameter int PB_W   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              key_act,
    input  logic              aux_req,
    input  logic [PA_W-1:0]   port_a_in,
    input  logic [PB_W-1:0]   port_b_in,
    input  logic              enc_a_in,
    input  logic              enc_b_in,
    output logic [DIV_W-1:0]  duty_div,
    output logic              standby,
    output logic              disp_on,
    output logic              com_blank,
    output logic              seg_blank,
    output logic              osc_en,
    output logic [PA_W-1:0]   port_a_out,
    output logic [PB_W-1:0]   port_b_out,
    output logic              enc_a_out,
    output logic              enc_b_out,
    output logic              key_req
);

    duty_code_e duty_code;
    logic       stb_enter;

    dsc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .duty_code (duty_code),
        .standby   (standby),
        .disp_on   (disp_on),
        .stb_enter (stb_enter)
    );

    dsc_wake u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .key_act (key_act),
        .aux_req (aux_req),
        .key_req (key_req),
        .osc_en  (osc_en)
    );

    dsc_outs #(.PA_W(PA_W), .PB_W(PB_W)) u_outs (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .disp_on    (disp_on),
        .stb_enter  (stb_enter),
        .port_a_in  (port_a_in),
        .port_b_in  (port_b_in),
        .enc_a_in   (enc_a_in),
        .enc_b_in   (enc_b_in),
        .com_blank  (com_blank),
        .seg_blank  (seg_blank),
        .port_a_out (port_a_out),
        .port_b_out (port_b_out),
        .enc_a_out  (enc_a_out),
        .enc_b_out  (enc_b_out)
    );

    // Translate the stored duty code into a divisor.
    always_comb duty_div = duty_to_div(duty_code);

endmodule

// File: rtl/dsc_chk.sv
// Module: dsc_chk
// Property checker for dsc_top, attached with bind below.
module dsc_chk #(
    parameter int PA_W = 4,
    parameter int PB_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            key_act,
    input logic            aux_req,
    input logic [3:0]      duty_div,
    input logic            standby,
    input logic            disp_on,
    input logic            com_blank,
    input logic            seg_blank,
    input logic            osc_en,
    input logic [PA_W-1:0] port_a_out,
    input logic [PB_W-1:0] port_b_out,
    input logic            enc_a_out,
    input logic            enc_b_out,
    input logic            key_req
);

    // R2
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_div == 4'd8 || duty_div == 4'd9 || duty_div == 4'd10);

    // R4
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_on || standby) |-> (com_blank && seg_blank));

    // R5
    port_a_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (port_a_out == '0));

    // R6
    port_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> $stable(port_b_out));

    // R7
    enc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!enc_a_out && !enc_b_out));

    // R8
    key_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_act |=> key_req);

    // R9
    aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !key_act) |=> !key_req);

    // R10
    osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (standby && !key_req));

endmodule

bind dsc_top dsc_chk #(.PA_W(PA_W), .PB_W(PB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_act    (key_act),
    .aux_req    (aux_req),
    .duty_div   (duty_div),
    .standby    (standby),
    .disp_on    (disp_on),
    .com_blank  (com_blank),
    .seg_blank  (seg_blank),
    .osc_en     (osc_en),
    .port_a_out (port_a_out),
    .port_b_out (port_b_out),
    .enc_a_out  (enc_a_out),
    .enc_b_out  (enc_b_out),
    .key_req    (key_req)
);

// File: tb/dsc_top_tb.sv
// Directed bench for dsc_top: one task per scenario, each checking itself.
module dsc_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       key_act = 1'b0;
    logic       aux_req = 1'b0;
    logic [3:0] port_a_in = '0;
    logic [3:0] port_b_in = '0;
    logic       enc_a_in = 1'b0;
    logic       enc_b_in = 1'b0;
    logic [3:0] duty_div;
    logic       standby, disp_on, com_blank, seg_blank, osc_en;
    logic [3:0] port_a_out, port_b_out;
    logic       enc_a_out, enc_b_out, key_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsc_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .key_act(key_act), .aux_req(aux_req),
        .port_a_in(port_a_in), .port_b_in(port_b_in),
        .enc_a_in(enc_a_in), .enc_b_in(enc_b_in),
        .duty_div(duty_div), .standby(standby), .disp_on(disp_on),
        .com_blank(com_blank), .seg_blank(seg_blank), .osc_en(osc_en),
        .port_a_out(port_a_out), .port_b_out(port_b_out),
        .enc_a_out(enc_a_out), .enc_b_out(enc_b_out), .key_req(key_req)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One register write; returns at the negedge after it lands.
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "duty_div", 8'(duty_div), 8'd8);
        check("R1", "standby", 8'(standby), 8'd0);
        check("R1", "disp_on", 8'(disp_on), 8'd0);
        check("R1", "blank", 8'({com_blank, seg_blank}), 8'd3);
        check("R1", "osc_en", 8'(osc_en), 8'd1);
        check("R1", "key_req", 8'(key_req), 8'd0);
    endtask

    task automatic t_duty();
        wr(1'b0, 8'h01); check("R2", "code01", 8'(duty_div), 8'd9);
        wr(1'b0, 8'hFE); check("R2", "code10 high bits", 8'(duty_div), 8'd10);
        wr(1'b0, 8'h03); check("R2", "code11", 8'(duty_div), 8'd10);
        wr(1'b0, 8'hFC); check("R2", "code00", 8'(duty_div), 8'd8);
        check("R3", "reg1 untouched by reg0", 8'({standby, disp_on}), 8'd0);
    endtask

    task automatic t_mode();
        wr(1'b1, 8'hFD);
        check("R3", "reg1 bits 7:2 ignored", 8'({standby, disp_on}), 8'd1);
        check("R4", "display on unblanks", 8'({com_blank, seg_blank}), 8'd0);
        wr(1'b0, 8'h02);
        check("R3", "reg0 write keeps reg1", 8'({standby, disp_on}), 8'd1);
        @(negedge clk);
        wr_sel = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        check("R11", "no strobe no change", 8'({standby, disp_on}), 8'd1);
        check("R11", "duty kept", 8'(duty_div), 8'd10);
        wr(1'b1, 8'h00);
        check("R4", "display off blanks", 8'({com_blank, seg_blank}), 8'd3);
        wr(1'b1, 8'h01);
    endtask

    task automatic t_normal_pass();
        port_a_in = 4'h9; port_b_in = 4'h6; enc_a_in = 1'b1; enc_b_in = 1'b1;
        #1;
        check("R5", "port A pass", 8'(port_a_out), 8'h09);
        check("R6", "port B pass", 8'(port_b_out), 8'h06);
        check("R7", "encoder pass", 8'({enc_a_out, enc_b_out}), 8'd3);
        @(negedge clk);
        aux_req = 1'b1; #1;
        check("R9", "aux not yet", 8'(key_req), 8'd0);
        @(negedge clk);
        check("R9", "aux raises flag", 8'(key_req), 8'd1);
        aux_req = 1'b0;
        @(negedge clk);
        check("R9", "aux released", 8'(key_req), 8'd0);
    endtask

    task automatic t_standby();
        port_b_in = 4'hA;
        wr(1'b1, 8'h03);
        port_b_in = 4'h5; port_a_in = 4'hF; #1;
        check("R4", "standby blanks", 8'({com_blank, seg_blank}), 8'd3);
        check("R6", "port B held", 8'(port_b_out), 8'h0A);
        check("R5", "port A low", 8'(port_a_out), 8'h00);
        check("R7", "encoder masked", 8'({enc_a_out, enc_b_out}), 8'd0);
        check("R10", "osc off idle", 8'(osc_en), 8'd0);
        aux_req = 1'b1;
        @(negedge clk);
        check("R9", "aux ignored in standby", 8'(key_req), 8'd0);
        aux_req = 1'b0;
        key_act = 1'b1; #1;
        check("R8", "flag lags press", 8'(key_req), 8'd0);
        @(negedge clk);
        check("R8", "key press flag", 8'(key_req), 8'd1);
        check("R10", "osc wakes", 8'(osc_en), 8'd1);
        repeat (3) @(negedge clk);
        check("R6", "port B still held", 8'(port_b_out), 8'h0A);
        key_act = 1'b0; #1;
        check("R8", "flag lags release", 8'(key_req), 8'd1);
        @(negedge clk);
        check("R8", "key release flag", 8'(key_req), 8'd0);
        check("R10", "osc sleeps", 8'(osc_en), 8'd0);
        wr(1'b1, 8'h01);
        check("R10", "osc on after exit", 8'(osc_en), 8'd1);
        check("R6", "port B follows after exit", 8'(port_b_out), 8'h05);
        check("R5", "port A follows after exit", 8'(port_a_out), 8'h0F);
    endtask

    task automatic t_normal_key();
        key_act = 1'b1;
        @(negedge clk);
        check("R8", "normal key press", 8'(key_req), 8'd1);
        key_act = 1'b0;
        @(negedge clk);
        check("R8", "normal key release", 8'(key_req), 8'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_duty();
        t_mode();
        t_normal_pass();
        t_standby();
        t_normal_key();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule